// File: doc/BRIEF.md
# Serial 1-1-0 Sequence Detector

This block watches a single-bit serial stream, consuming exactly one bit on each rising clock edge, and raises a one-bit flag when the three most recent bits, in arrival order, were a 1, then a 1, then a 0. It is a Moore finite state machine. The flag comes only from the state register, so it is glitch-free and can drive downstream logic directly.

Once a match completes, the machine treats itself as freshly started. None of the bits that formed the match contribute to a later one. The state fits in two flip-flops: idle, one 1 seen, two or more 1s seen, and match reported. A run of several 1s followed by a 0 counts as a single match, because extra 1s keep the machine in the two-ones state.

A typical use is framing or marker spotting on a slow serial line. The caller presents a bit on `data_i` every cycle and reads `detect_o` one cycle after the edge that consumed the closing 0.

Top module: `bit_triplet_detector`

## Requirements
- R1: While `rst_ni` is low, `detect_o` is 0. Bits seen before reset is released never contribute to a match.
- R2: If the clock edge at which `data_i` is 0 follows two consecutively consumed 1s, `detect_o` is 1 in the following cycle.
- R3: `detect_o` is never high in two consecutive cycles.
- R4: After a match, the machine restarts from idle. A following 1, 0 gives no detection, and a following 1, 1, 0 gives exactly one new detection.
- R5: A run of any number (two or more) of 1s followed by a 0 yields exactly one detection.
- R6: A 0 consumed with fewer than two 1s pending returns the machine to idle. The stream 1, 0, 1, 0 gives no detection, and 1, 0, 1, 1, 0 gives one.
- R7: `detect_o` is 0 in any cycle after an edge that consumed a 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one serial bit is consumed per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to the idle state |
| data_i | input | 1 | Serial data bit |
| detect_o | output | 1 | High for one cycle after the 1-1-0 pattern completes |

## Verification
The state register is the only memory, so a wrong state shows up at `detect_o` within at most three consumed bits. A state that wrongly holds partial history produces an extra pulse or a missing pulse as soon as the next 0 arrives. A corrupted match state shows as a two-cycle pulse or a pulse after a 1, visible in the very next cycle. Random streams with a bias toward 1s reach the two-ones and match states often, so each such fault is reported within a few cycles of where it first appears.

// File: rtl/trip_pkg.sv
package trip_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ONE   = 2'b01,
    ST_TWO   = 2'b11,
    ST_FOUND = 2'b10
  } trip_state_e;
endpackage

// File: rtl/trip_next_state.sv
module trip_next_state
  import trip_pkg::*;
(
  input  trip_state_e cur_i,
  input  logic        bit_i,
  output trip_state_e nxt_o
);
  always_comb begin
    unique case (cur_i)
      ST_IDLE:  nxt_o = bit_i ? ST_ONE : ST_IDLE;
      ST_ONE:   nxt_o = bit_i ? ST_TWO : ST_IDLE;
      ST_TWO:   nxt_o = bit_i ? ST_TWO : ST_FOUND;
      // found behaves as a fresh start: no match bits reused
      ST_FOUND: nxt_o = bit_i ? ST_ONE : ST_IDLE;
      default:  nxt_o = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/trip_state_reg.sv
module trip_state_reg
  import trip_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_i,
  input  trip_state_e nxt_i,
  output trip_state_e cur_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_o <= ST_IDLE;
    else         cur_o <= nxt_i;
  end

  assert_two_then_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o == ST_TWO && !bit_i) |=> (cur_o == ST_FOUND));

  assert_found_restarts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o == ST_FOUND && bit_i) |=> (cur_o == ST_ONE));

  assert_ones_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_o == ST_TWO && bit_i) |=> (cur_o == ST_TWO));

  assert_short_zero_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cur_o == ST_IDLE || cur_o == ST_ONE) && !bit_i) |=> (cur_o == ST_IDLE));
endmodule

// File: rtl/trip_detect_decode.sv
module trip_detect_decode
  import trip_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bit_i,
  input  trip_state_e cur_i,
  output logic        hit_o
);
  assign hit_o = (cur_i == ST_FOUND);

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);

  assert_hit_after_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_i |=> !hit_o);
endmodule

// File: rtl/bit_triplet_detector.sv
module bit_triplet_detector
  import trip_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic detect_o
);
  trip_state_e cur_q;
  trip_state_e nxt_d;

  trip_next_state u_next (
    .cur_i (cur_q),
    .bit_i (data_i),
    .nxt_o (nxt_d)
  );

  trip_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (data_i),
    .nxt_i  (nxt_d),
    .cur_o  (cur_q)
  );

  trip_detect_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (data_i),
    .cur_i  (cur_q),
    .hit_o  (detect_o)
  );
endmodule

// File: tb/bit_triplet_detector_bench.sv
module bit_triplet_detector_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic det;

  int checks = 0;
  int errors = 0;
  logic [2:0] hist = 3'b000;
  int unsigned fresh = 0;

  always #4 clk = ~clk;

  bit_triplet_detector u_bit_triplet_detector (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .data_i   (din),
    .detect_o (det)
  );

  // expected flag: last three bits since restart were 1,1,0
  function automatic logic exp_hit(input logic [2:0] h, input int unsigned n);
    return (n >= 3) && (h == 3'b110);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: detect_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input string tag);
    logic e;
    @(negedge clk);
    din = b;
    @(posedge clk);
    #1;
    hist = {hist[1:0], b};
    fresh++;
    e = exp_hit(hist, fresh);
    if (e) fresh = 0;
    check(tag, det, e);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", det, 1'b0);
    hist = 3'b000;
    fresh = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic b;
    string t;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    check("R1", det, 1'b0);
    rst_n = 1'b1;

    step(1, "R2"); step(1, "R7"); step(0, "R2");
    step(0, "R3");
    step(1, "R4"); step(1, "R4"); step(0, "R4");
    step(1, "R4"); step(0, "R4");
    step(1, "R5"); step(1, "R5"); step(1, "R5"); step(1, "R5"); step(1, "R5"); step(0, "R5");
    step(0, "R3");
    step(1, "R6"); step(0, "R6"); step(1, "R6"); step(0, "R6");
    step(1, "R6"); step(0, "R6"); step(1, "R6"); step(1, "R6"); step(0, "R6");

    // R1: history before reset must not count
    step(1, "R1"); step(1, "R1");
    do_reset();
    step(0, "R1");
    step(1, "R1"); step(0, "R1");

    for (int i = 0; i < 3000; i++) begin
      b = ($urandom % 3) != 0;
      t = b ? "R7" : "R2";
      step(b, t);
      if (i == 1500) do_reset();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule